// File: doc/BRIEF.md
# Dynamic-Priority Shared Bus Arbiter

This block decides which of several processors may drive a shared system bus. Each processor has a priority register. A hardware task scheduler rewrites these registers at run time through a separate priority write port. Because the scheduler keeps each register equal to the priority of the task the processor is running, bus access follows task importance and not a fixed wiring order. A processor that happens to sit on a favoured port, but runs an unimportant task, therefore cannot hold off an urgent task on the bus.

When the bus is free, the arbiter compares the priorities of all processors that are requesting and grants the bus to the highest one. If several requesters share the top value, a round-robin pointer chooses among them. The pointer starts just after the processor that was granted most recently. The owner keeps the bus until it withdraws its request or pulses the release input. The bus then spends one cycle free before the next arbitration. A larger register value means a higher priority.

Top module: `dyn_bus_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is removed, `grant` is all zero and `bus_busy` is low. Each priority register resets to the index of its processor, so processor 3 outranks processor 0 until the first write.
- R2: If the bus is free and at least one `req` bit is set, then on the next rising edge `grant` becomes one-hot on the requester whose priority register holds the largest value.
- R3: When several requesters share the largest priority value, the grant goes to the first of them found by scanning upward, with wrap-around, from the index just after the most recently granted processor. After reset the scan starts at index 0.
- R4: `grant` is always one-hot or all zero. `bus_busy` is high exactly when `grant` is non-zero.
- R5: While the owner keeps its `req` bit set and `bus_release` is low, `grant` does not change, even when a requester with higher priority appears.
- R6: If the owner clears its `req` bit or raises `bus_release`, `grant` is all zero after the next edge. A new grant can appear at the edge after that.
- R7: A priority write (`pw_valid` with `pw_cpu` and `pw_prio`) updates that processor's register on the next edge. An arbitration at that same edge still uses the old value. A write never removes a grant already held.
- R8: If no `req` bit is set in a cycle, `grant` is all zero after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NUM_CPU | Bus request, one bit per processor |
| bus_release | input | 1 | Owner gives up the bus |
| pw_valid | input | 1 | Priority write strobe |
| pw_cpu | input | IDX_W | Processor whose register is written |
| pw_prio | input | PRIO_W | New priority value (larger is higher) |
| grant | output | NUM_CPU | One-hot bus grant |
| bus_busy | output | 1 | Bus currently owned |

## Verification
All four processors request together with the reset priorities, and the grant must go to the top index. This separates a design that compares register values from a plain fixed-port priority. With all priorities made equal, repeated release-and-regrant cycles must walk the grant through every index in order and wrap around. This shows whether the round-robin pointer really moves past the last winner. Priority writes made while a processor owns the bus, and one made on the same edge as an arbitration, separate a design that updates its registers on the next edge without disturbing the current owner from one that revokes the grant or reads the new value early. Partial request sets that include a low-priority processor confirm that the grant goes only to requesters and that an empty request set leaves the bus idle.

// File: rtl/dba_pkg.sv
package dba_pkg;
    localparam int NUM_CPU = 4;
    localparam int PRIO_W  = 3;
    localparam int IDX_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

    typedef logic [PRIO_W-1:0]  prio_t;
    typedef logic [IDX_W-1:0]   cpu_idx_t;
    typedef logic [NUM_CPU-1:0] cpu_vec_t;

    typedef enum logic { BUS_FREE, BUS_OWNED } bus_state_e;

    typedef struct packed {
        logic     valid;
        cpu_idx_t cpu;
        prio_t    prio;
    } prio_wr_t;

    typedef struct packed {
        logic     valid;
        cpu_idx_t cpu;
    } pick_t;

    function automatic cpu_idx_t next_idx(cpu_idx_t i);
        if (int'(i) == NUM_CPU - 1) return '0;
        return i + cpu_idx_t'(1);
    endfunction

    function automatic cpu_vec_t to_onehot(cpu_idx_t i);
        cpu_vec_t v;
        v = '0;
        v[i] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/dba_prio_regs.sv
module dba_prio_regs
    import dba_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  prio_wr_t wr,
    output prio_t    prio_q [NUM_CPU]
);
    for (genvar g = 0; g < NUM_CPU; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                prio_q[g] <= prio_t'(g);
            else if (wr.valid && wr.cpu == cpu_idx_t'(g))
                prio_q[g] <= wr.prio;
        end
    end
endmodule

// File: rtl/dba_select.sv
module dba_select
    import dba_pkg::*;
(
    input  cpu_vec_t req,
    input  prio_t    prio_q [NUM_CPU],
    input  cpu_idx_t start_ptr,
    output pick_t    pick
);
    prio_t best;

    always_comb begin
        pick = '0;
        best = '0;
        for (int k = 0; k < NUM_CPU; k++) begin
            cpu_idx_t ci;
            ci = cpu_idx_t'((int'(start_ptr) + k) % NUM_CPU);
            if (req[ci] && (!pick.valid || prio_q[ci] > best)) begin
                pick.valid = 1'b1;
                pick.cpu   = ci;
                best       = prio_q[ci];
            end
        end
    end
endmodule

// File: rtl/dba_grant_ctrl.sv
module dba_grant_ctrl
    import dba_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cpu_vec_t req,
    input  logic     bus_release,
    input  pick_t    pick,
    output cpu_idx_t rr_ptr,
    output cpu_vec_t grant,
    output logic     bus_busy
);
    bus_state_e state;
    cpu_idx_t   owner;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= BUS_FREE;
            owner  <= '0;
            rr_ptr <= '0;
            grant  <= '0;
        end else begin
            case (state)
                BUS_FREE: begin
                    if (pick.valid) begin
                        state  <= BUS_OWNED;
                        owner  <= pick.cpu;
                        rr_ptr <= next_idx(pick.cpu);
                        grant  <= to_onehot(pick.cpu);
                    end
                end
                BUS_OWNED: begin
                    if (!req[owner] || bus_release) begin
                        state <= BUS_FREE;
                        grant <= '0;
                    end
                end
                default: state <= BUS_FREE;
            endcase
        end
    end

    assign bus_busy = (state == BUS_OWNED);
endmodule

// File: rtl/dyn_bus_arbiter.sv
module dyn_bus_arbiter
    import dba_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CPU-1:0] req,
    input  logic               bus_release,
    input  logic               pw_valid,
    input  logic [IDX_W-1:0]   pw_cpu,
    input  logic [PRIO_W-1:0]  pw_prio,
    output logic [NUM_CPU-1:0] grant,
    output logic               bus_busy
);
    prio_wr_t wr;
    prio_t    prio_q [NUM_CPU];
    cpu_idx_t rr_ptr;
    pick_t    pick;

    assign wr = '{valid: pw_valid, cpu: pw_cpu, prio: pw_prio};

    dba_prio_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .prio_q (prio_q)
    );

    dba_select u_sel (
        .req       (req),
        .prio_q    (prio_q),
        .start_ptr (rr_ptr),
        .pick      (pick)
    );

    dba_grant_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .bus_release (bus_release),
        .pick        (pick),
        .rr_ptr      (rr_ptr),
        .grant       (grant),
        .bus_busy    (bus_busy)
    );
endmodule

// File: rtl/dba_checker.sv
module dba_checker
    import dba_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [NUM_CPU-1:0] req,
    input logic               bus_release,
    input logic [NUM_CPU-1:0] grant,
    input logic               bus_busy
);
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R4
    AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (rst)
        bus_busy == (grant != '0)); // R4
    AST_OWNER_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((grant != '0) && ((grant & req) != '0) && !bus_release) |=> grant == $past(grant)); // R5
    AST_OWNER_DROP: assert property (@(posedge clk) disable iff (rst)
        ((grant != '0) && (((grant & req) == '0) || bus_release)) |=> grant == '0); // R6
    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |=> grant == '0); // R8
    AST_GRANT_TO_REQ: assert property (@(posedge clk) disable iff (rst)
        ((grant == '0) && (req != '0)) |=> (grant & $past(req)) != '0); // R2
endmodule

bind dyn_bus_arbiter dba_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .bus_release (bus_release),
    .grant       (grant),
    .bus_busy    (bus_busy)
);

// File: tb/tb_dyn_bus_arbiter.sv
`timescale 1ns/1ps
module tb_dyn_bus_arbiter;
    import dba_pkg::*;

    logic               clk = 1'b0;
    logic               rst;
    logic [NUM_CPU-1:0] req;
    logic               bus_release;
    logic               pw_valid;
    logic [IDX_W-1:0]   pw_cpu;
    logic [PRIO_W-1:0]  pw_prio;
    logic [NUM_CPU-1:0] grant;
    logic               bus_busy;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dyn_bus_arbiter dut (
        .clk(clk), .rst(rst), .req(req), .bus_release(bus_release),
        .pw_valid(pw_valid), .pw_cpu(pw_cpu), .pw_prio(pw_prio),
        .grant(grant), .bus_busy(bus_busy)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_grant(input logic [NUM_CPU-1:0] exp, input string tag);
        checks++;
        if (grant !== exp || bus_busy !== (exp != '0)) begin
            errors++;
            $display("FAIL %s: grant=%b busy=%b expected grant=%b busy=%b",
                     tag, grant, bus_busy, exp, (exp != '0));
        end
    endtask

    task automatic set_prio(input int cpu, input int p);
        pw_valid = 1'b1;
        pw_cpu   = IDX_W'(cpu);
        pw_prio  = PRIO_W'(p);
        step();
        pw_valid = 1'b0;
    endtask

    task automatic release_and_regrant(input logic [NUM_CPU-1:0] exp, input string tag);
        bus_release = 1'b1;
        step();
        expect_grant('0, "R6 release frees bus");
        bus_release = 1'b0;
        step();
        expect_grant(exp, tag);
    endtask

    task automatic t_reset();
        rst = 1'b1; req = '0; bus_release = 1'b0;
        pw_valid = 1'b0; pw_cpu = '0; pw_prio = '0;
        repeat (3) step();
        rst = 1'b0;
        expect_grant('0, "R1 reset idle");
        step();
        expect_grant('0, "R1 idle after reset");
    endtask

    task automatic t_reset_order();
        req = 4'b1111;
        step();
        expect_grant(4'b1000, "R1 R2 reset priorities favour index 3");
        release_and_regrant(4'b1000, "R2 highest value wins again");
    endtask

    task automatic t_round_robin();
        for (int i = 0; i < NUM_CPU; i++) set_prio(i, 5);
        expect_grant(4'b1000, "R7 writes keep current grant");
        release_and_regrant(4'b0001, "R3 tie cpu0");
        release_and_regrant(4'b0010, "R3 tie cpu1");
        release_and_regrant(4'b0100, "R3 tie cpu2");
        release_and_regrant(4'b1000, "R3 tie cpu3");
        release_and_regrant(4'b0001, "R3 tie wraps to cpu0");
    endtask

    task automatic t_dynamic();
        set_prio(2, 7);
        expect_grant(4'b0001, "R5 higher requester does not preempt");
        release_and_regrant(4'b0100, "R2 raised priority wins");
        set_prio(2, 0);
        expect_grant(4'b0100, "R7 lowering owner keeps grant");
        req = 4'b1011;
        step();
        expect_grant('0, "R6 owner drops request");
        step();
        expect_grant(4'b1000, "R3 pointer after cpu2 selects cpu3");
    endtask

    task automatic t_empty_and_partial();
        req = '0;
        step();
        expect_grant('0, "R8 no requests");
        step();
        expect_grant('0, "R8 stays idle");
        req = 4'b0101;
        step();
        expect_grant(4'b0001, "R2 low-priority cpu2 loses");
        checks++;
        if (bus_busy !== 1'b1) begin
            errors++;
            $display("FAIL R4: busy=%b expected 1", bus_busy);
        end
        req = '0;
        step();
        expect_grant('0, "R8 cleared");
    endtask

    task automatic t_write_same_edge();
        req      = 4'b0011;
        pw_valid = 1'b1; pw_cpu = IDX_W'(0); pw_prio = PRIO_W'(7);
        step();
        pw_valid = 1'b0;
        expect_grant(4'b0010, "R7 arbitration uses old value");
        release_and_regrant(4'b0001, "R7 new value used next time");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_reset_order();
        t_round_robin();
        t_dynamic();
        t_empty_and_partial();
        t_write_same_edge();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule